// File: doc/BRIEF.md
# USB Endpoint Status Tracker

This block holds the per-endpoint status of a full-speed USB device controller with sixteen endpoints. Endpoint index 0 is the control OUT endpoint, index 1 is the control IN endpoint, and indices 2 to 15 are data endpoints 1 to 14. Each endpoint has two packet buffers used in ping-pong order. The block tracks whether each buffer is full, the toggle of the last packet taken in, the stall state, the SETUP bookkeeping of the control endpoints, which buffer the CPU side is working on, and one interrupt bit per endpoint.

Three sources change the state. The CPU issues byte-wide commands to stall, unstall or read an endpoint. The serial engine reports good packets and SETUP tokens, and it reports when the SETUP data has been fully written. The CPU or DMA side pulses a drain strobe when it has emptied the buffer it holds. A read returns one status word one cycle after the command. The word shows the state as it was before that cycle's updates. The read also clears the endpoint's interrupt bit, and it may clear the overwrite flag.

Top module: `ep_stat_tracker`

## Requirements
- R1: After reset every status word reads 0x00, `irq` is all zeros and `rd_valid` is low.
- R2: Command 0x50+n reads endpoint n, where n=0 is control OUT, n=1 is control IN and n=2..15 are endpoints 1..14. One cycle later `rd_valid` is high for exactly one cycle, and `rd_word` holds {bit7 stall, bit6 secondary full, bit5 primary full, bit4 PID, bit3 overwrite, bit2 setup present, bit1 CPU buffer, bit0 = 0} as it was before the command's cycle.
- R3: A read of endpoint n clears `irq[n]`, unless a packet is accepted on n in the same cycle.
- R4: Command 0x40+n sets the stall bit of endpoint n and command 0x80+n clears it. Any code whose upper nibble is not 4, 5 or 8 changes nothing.
- R5: A SETUP token on any endpoint clears its stall bit, and this takes priority over a stall command in the same cycle.
- R6: A good packet on endpoint n with not both buffers full is accepted. It sets the full bit of the buffer the USB side targets (primary first, then alternating), stores its PID (0 = DATA0, 1 = DATA1) in bit 4 and sets `irq[n]`.
- R7: A good packet on an endpoint whose two buffers are both full is dropped. The full bits and the PID do not change and no interrupt is raised.
- R8: A drain strobe clears the full bit of the buffer named by the CPU buffer bit and then toggles that bit (0 = primary, 1 = secondary). A drain while that buffer is empty is ignored.
- R9: A SETUP token on endpoint 0 or 1 sets the setup-present bit, and an accepted drain on that endpoint clears it. A SETUP token on endpoints 2..15 never sets it.
- R10: A SETUP token on a control endpoint whose setup-present bit is already set sets the overwrite bit.
- R11: A read clears the overwrite bit only if the setup-done strobe has been seen on that endpoint since its last SETUP token. Otherwise the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe from the CPU |
| cmd_code | input | 8 | Command code (stall 0x4n, read 0x5n, unstall 0x8n) |
| rd_valid | output | 1 | Status word valid, one cycle after a read command |
| rd_word | output | 8 | Status word of the endpoint that was read |
| pkt_valid | input | 1 | Good packet received by the serial engine |
| pkt_ep | input | 4 | Endpoint index of the packet |
| pkt_pid | input | 1 | Data toggle of the packet |
| setup_valid | input | 1 | SETUP token received |
| setup_done | input | 1 | SETUP data fully written |
| setup_ep | input | 4 | Endpoint index of the SETUP token or done strobe |
| drain_valid | input | 1 | CPU/DMA finished the buffer it holds |
| drain_ep | input | 4 | Endpoint index of the drain |
| irq | output | 16 | Per-endpoint interrupt bits |

## Verification
The hardest state to reach from the ports is the overwrite bit surviving a read. It needs a control endpoint that already holds an unacknowledged SETUP, then a second SETUP token, then a read before the done strobe. The same endpoint must then be read again after the done strobe, to show the conditional clear. The bench builds this on endpoint 0. It first stalls the endpoint so the same token also shows the automatic unstall. It then repeats the setup, done and drain steps, with the full-buffer rejection and the empty-buffer drain, on other endpoints. A behavioural model predicts every status word and interrupt bit.

// File: rtl/ep_stat_pkg.sv
package ep_stat_pkg;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_STALL,
    CMD_UNSTALL,
    CMD_READ
  } cmd_kind_e;

  // Field order equals the bit order of the status word (bit 7 down to bit 1)
  typedef struct packed {
    logic stall;
    logic full1;
    logic full0;
    logic pid;
    logic ovw;
    logic setp;
    logic cpu_sel;
  } ep_stat_t;

  function automatic cmd_kind_e cmd_kind(input logic [7:0] code);
    case (code[7:4])
      4'h4:    return CMD_STALL;
      4'h5:    return CMD_READ;
      4'h8:    return CMD_UNSTALL;
      default: return CMD_NONE;
    endcase
  endfunction

  function automatic logic [7:0] stat_word(input ep_stat_t s);
    return {s, 1'b0};
  endfunction

  function automatic logic buf_full(input ep_stat_t s, input logic sel);
    return sel ? s.full1 : s.full0;
  endfunction

  function automatic logic both_full(input ep_stat_t s);
    return s.full0 & s.full1;
  endfunction

endpackage

// File: rtl/ep_cmd_decode.sv
module ep_cmd_decode
  import ep_stat_pkg::*;
#(
  parameter int NUM_EP = 16,
  localparam int EPW   = $clog2(NUM_EP)
) (
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  output logic [NUM_EP-1:0] stall_oh,
  output logic [NUM_EP-1:0] unstall_oh,
  output logic [NUM_EP-1:0] read_oh,
  output logic              read_any,
  output logic [EPW-1:0]    read_sel
);

  cmd_kind_e  kind;
  logic [3:0] idx;

  assign kind     = cmd_kind(cmd_code);
  assign idx      = cmd_code[3:0];
  assign read_sel = cmd_code[EPW-1:0];

  always_comb begin
    for (int i = 0; i < NUM_EP; i++) begin
      stall_oh[i]   = cmd_valid && (kind == CMD_STALL)   && (idx == 4'(i));
      unstall_oh[i] = cmd_valid && (kind == CMD_UNSTALL) && (idx == 4'(i));
      read_oh[i]    = cmd_valid && (kind == CMD_READ)    && (idx == 4'(i));
    end
  end

  assign read_any = |read_oh;

endmodule

// File: rtl/ep_slot.sv
module ep_slot
  import ep_stat_pkg::*;
#(
  parameter bit IS_CTRL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stall_req,
  input  logic       unstall_req,
  input  logic       read_req,
  input  logic       pkt_hit,
  input  logic       pkt_pid,
  input  logic       setup_hit,
  input  logic       done_hit,
  input  logic       drain_hit,
  output logic [7:0] status,
  output logic       irq
);

  ep_stat_t st, st_n;
  logic     usb_sel, usb_sel_n;
  logic     busy, busy_n;
  logic     irq_n;

  // named internal events
  logic accept;
  logic drain_ok;
  logic ovw_clr;
  logic ovw_set;

  assign accept   = pkt_hit && !both_full(st);
  assign drain_ok = drain_hit && buf_full(st, st.cpu_sel);
  assign ovw_set  = IS_CTRL && setup_hit && st.setp;
  assign ovw_clr  = read_req && !busy;

  always_comb begin
    st_n      = st;
    usb_sel_n = usb_sel;
    busy_n    = busy;
    irq_n     = irq;

    // stall: SETUP token has the last word
    if (unstall_req) st_n.stall = 1'b0;
    if (stall_req)   st_n.stall = 1'b1;
    if (setup_hit)   st_n.stall = 1'b0;

    // CPU side drain
    if (drain_ok) begin
      if (st.cpu_sel) st_n.full1 = 1'b0;
      else            st_n.full0 = 1'b0;
      st_n.cpu_sel = ~st.cpu_sel;
      st_n.setp    = 1'b0;
    end

    // USB side fill
    if (accept) begin
      if (usb_sel) st_n.full1 = 1'b1;
      else         st_n.full0 = 1'b1;
      usb_sel_n = ~usb_sel;
      st_n.pid  = pkt_pid;
    end

    // setup bookkeeping
    if (IS_CTRL) begin
      if (done_hit)  busy_n = 1'b0;
      if (setup_hit) begin
        busy_n    = 1'b1;
        st_n.setp = 1'b1;
      end
    end
    if (ovw_clr) st_n.ovw = 1'b0;
    if (ovw_set) st_n.ovw = 1'b1;

    // interrupt: set wins over read clear
    if (read_req) irq_n = 1'b0;
    if (accept)   irq_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= '0;
      usb_sel <= 1'b0;
      busy    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      st      <= st_n;
      usb_sel <= usb_sel_n;
      busy    <= busy_n;
      irq     <= irq_n;
    end
  end

  assign status = stat_word(st);

  AST_SETUP_UNSTALL: assert property (@(posedge clk) disable iff (!rst_n)
    setup_hit |=> !st.stall); // R5
  AST_STALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req && !setup_hit |=> st.stall); // R4
  AST_UNSTALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    unstall_req && !stall_req |=> !st.stall); // R4
  AST_READ_CLR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    read_req && !pkt_hit |=> !irq); // R3
  AST_ACCEPT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_hit && !(st.full0 && st.full1) |=> irq && (st.full0 || st.full1)); // R6
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_hit && st.full0 && st.full1 && !drain_hit |=> st.full0 && st.full1 && $stable(st.pid)); // R7
  AST_FULL_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_hit && st.full0 && st.full1 && !irq && !read_req |=> !irq); // R7
  AST_PINGPONG: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full(st, usb_sel) |-> (st.full0 && st.full1)); // R8
  AST_DRAIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    drain_hit && buf_full(st, st.cpu_sel) |=> st.cpu_sel != $past(st.cpu_sel)); // R8
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    drain_hit && !buf_full(st, st.cpu_sel) |=> $stable(st.cpu_sel)); // R8
  AST_OVW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    read_req && busy && st.ovw |=> st.ovw); // R11

  generate
    if (IS_CTRL) begin : g_ctrl_chk
      AST_SETP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        setup_hit |=> st.setp); // R9
      AST_OVW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        setup_hit && st.setp |=> st.ovw); // R10
    end
  endgenerate

endmodule

// File: rtl/ep_status_port.sv
module ep_status_port #(
  parameter int NUM_EP = 16,
  localparam int EPW   = $clog2(NUM_EP)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   read_any,
  input  logic [EPW-1:0]         read_sel,
  input  logic [NUM_EP-1:0][7:0] status_all,
  output logic                   rd_valid,
  output logic [7:0]             rd_word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_word  <= 8'h00;
    end else begin
      rd_valid <= read_any;
      if (read_any) rd_word <= status_all[read_sel];
    end
  end

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    read_any |=> rd_valid); // R2
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !read_any |=> !rd_valid); // R2

endmodule

// File: rtl/ep_stat_tracker.sv
module ep_stat_tracker
  import ep_stat_pkg::*;
#(
  parameter int NUM_EP  = 16,
  parameter int NUM_CTRL = 2,
  localparam int EPW    = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  output logic              rd_valid,
  output logic [7:0]        rd_word,
  input  logic              pkt_valid,
  input  logic [EPW-1:0]    pkt_ep,
  input  logic              pkt_pid,
  input  logic              setup_valid,
  input  logic              setup_done,
  input  logic [EPW-1:0]    setup_ep,
  input  logic              drain_valid,
  input  logic [EPW-1:0]    drain_ep,
  output logic [NUM_EP-1:0] irq
);

  logic [NUM_EP-1:0]      stall_oh, unstall_oh, read_oh;
  logic                   read_any;
  logic [EPW-1:0]         read_sel;
  logic [NUM_EP-1:0]      pkt_oh, setup_oh, done_oh, drain_oh;
  logic [NUM_EP-1:0][7:0] status_all;

  ep_cmd_decode #(.NUM_EP(NUM_EP)) u_dec (
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .stall_oh   (stall_oh),
    .unstall_oh (unstall_oh),
    .read_oh    (read_oh),
    .read_any   (read_any),
    .read_sel   (read_sel)
  );

  always_comb begin
    for (int i = 0; i < NUM_EP; i++) begin
      pkt_oh[i]   = pkt_valid   && (pkt_ep   == EPW'(i));
      setup_oh[i] = setup_valid && (setup_ep == EPW'(i));
      done_oh[i]  = setup_done  && (setup_ep == EPW'(i));
      drain_oh[i] = drain_valid && (drain_ep == EPW'(i));
    end
  end

  generate
    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
      ep_slot #(.IS_CTRL(g < NUM_CTRL)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall_req   (stall_oh[g]),
        .unstall_req (unstall_oh[g]),
        .read_req    (read_oh[g]),
        .pkt_hit     (pkt_oh[g]),
        .pkt_pid     (pkt_pid),
        .setup_hit   (setup_oh[g]),
        .done_hit    (done_oh[g]),
        .drain_hit   (drain_oh[g]),
        .status      (status_all[g]),
        .irq         (irq[g])
      );
    end
  endgenerate

  ep_status_port #(.NUM_EP(NUM_EP)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .read_any   (read_any),
    .read_sel   (read_sel),
    .status_all (status_all),
    .rd_valid   (rd_valid),
    .rd_word    (rd_word)
  );

  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(read_oh)); // R2

endmodule

// File: tb/sim_ep_stat_tracker.sv
module sim_ep_stat_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic        rd_valid;
  logic [7:0]  rd_word;
  logic        pkt_valid = 1'b0;
  logic [3:0]  pkt_ep = 4'h0;
  logic        pkt_pid = 1'b0;
  logic        setup_valid = 1'b0;
  logic        setup_done = 1'b0;
  logic [3:0]  setup_ep = 4'h0;
  logic        drain_valid = 1'b0;
  logic [3:0]  drain_ep = 4'h0;
  logic [15:0] irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ep_stat_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .rd_valid(rd_valid), .rd_word(rd_word), .pkt_valid(pkt_valid),
    .pkt_ep(pkt_ep), .pkt_pid(pkt_pid), .setup_valid(setup_valid),
    .setup_done(setup_done), .setup_ep(setup_ep), .drain_valid(drain_valid),
    .drain_ep(drain_ep), .irq(irq)
  );

  // behavioural model
  bit [15:0] m_stall, m_f0, m_f1, m_pid, m_ovw, m_setp, m_cpu, m_usb, m_busy, m_irq;

  function automatic logic [7:0] m_word(int e);
    return {m_stall[e], m_f1[e], m_f0[e], m_pid[e], m_ovw[e], m_setp[e], m_cpu[e], 1'b0};
  endfunction

  // scoreboard
  logic [7:0] exp_w[$];
  string      exp_tag[$];

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      total++;
      if (exp_w.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected rd_valid: actual=%02h expected=none", rd_word);
      end else begin
        logic [7:0] w;
        string t;
        w = exp_w.pop_front();
        t = exp_tag.pop_front();
        if (rd_word !== w) begin
          bad++;
          $display("FAIL %s status word: actual=%02h expected=%02h", t, rd_word, w);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic pulse_cmd(logic [7:0] c);
    cyc(); cmd_valid = 1'b1; cmd_code = c;
    cyc(); cmd_valid = 1'b0;
  endtask

  task automatic t_read(int e, string tag);
    exp_w.push_back(m_word(e));
    exp_tag.push_back(tag);
    m_irq[e] = 1'b0;
    if (!m_busy[e]) m_ovw[e] = 1'b0;
    pulse_cmd(8'h50 + 8'(e));
  endtask

  task automatic t_stall(int e);
    m_stall[e] = 1'b1;
    pulse_cmd(8'h40 + 8'(e));
  endtask

  task automatic t_unstall(int e);
    m_stall[e] = 1'b0;
    pulse_cmd(8'h80 + 8'(e));
  endtask

  task automatic t_pkt(int e, bit p);
    if (!(m_f0[e] && m_f1[e])) begin
      if (m_usb[e]) m_f1[e] = 1'b1; else m_f0[e] = 1'b1;
      m_usb[e] = ~m_usb[e];
      m_pid[e] = p;
      m_irq[e] = 1'b1;
    end
    cyc(); pkt_valid = 1'b1; pkt_ep = 4'(e); pkt_pid = p;
    cyc(); pkt_valid = 1'b0;
  endtask

  task automatic t_drain(int e);
    if (m_cpu[e] ? m_f1[e] : m_f0[e]) begin
      if (m_cpu[e]) m_f1[e] = 1'b0; else m_f0[e] = 1'b0;
      m_cpu[e] = ~m_cpu[e];
      m_setp[e] = 1'b0;
    end
    cyc(); drain_valid = 1'b1; drain_ep = 4'(e);
    cyc(); drain_valid = 1'b0;
  endtask

  task automatic t_setup(int e);
    m_stall[e] = 1'b0;
    if (e < 2) begin
      if (m_setp[e]) m_ovw[e] = 1'b1;
      m_setp[e] = 1'b1;
      m_busy[e] = 1'b1;
    end
    cyc(); setup_valid = 1'b1; setup_ep = 4'(e);
    cyc(); setup_valid = 1'b0;
  endtask

  task automatic t_done(int e);
    if (e < 2) m_busy[e] = 1'b0;
    cyc(); setup_done = 1'b1; setup_ep = 4'(e);
    cyc(); setup_done = 1'b0;
  endtask

  task automatic chk_irq(int e, string tag);
    total++;
    if (irq[e] !== m_irq[e]) begin
      bad++;
      $display("FAIL %s irq[%0d]: actual=%0b expected=%0b", tag, e, irq[e], m_irq[e]);
    end
  endtask

  bit finished = 1'b0;

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    total++;
    if (irq !== 16'h0 || rd_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset outputs: actual=%04h/%0b expected=0000/0", irq, rd_valid);
    end
    rst_n = 1'b1;
    for (int e = 0; e < 16; e++) t_read(e, "R1");

    // R4 stall / unstall, R2 order
    t_stall(5);
    t_read(5, "R4");
    t_read(4, "R2");
    t_unstall(5);
    t_read(5, "R4");
    t_stall(3);
    pulse_cmd(8'h23);
    pulse_cmd(8'h93);
    t_read(3, "R4");
    t_stall(15);
    t_read(15, "R2");

    // R6 packet accept, R3 read clears irq
    t_pkt(7, 1'b1);
    chk_irq(7, "R6");
    t_read(7, "R6");
    chk_irq(7, "R3");
    t_pkt(7, 1'b0);
    t_read(7, "R6");
    // R7 both full
    t_pkt(7, 1'b1);
    chk_irq(7, "R7");
    t_read(7, "R7");
    // R8 drain order
    t_drain(7);
    t_read(7, "R8");
    t_drain(7);
    t_read(7, "R8");
    t_drain(7);
    t_read(7, "R8");
    t_pkt(7, 1'b1);
    t_read(7, "R6");

    // R5, R9, R10, R11 on control OUT
    t_stall(0);
    t_setup(0);
    t_read(0, "R5");
    t_setup(0);
    t_read(0, "R10");
    t_read(0, "R11");
    t_done(0);
    t_read(0, "R11");
    t_read(0, "R11");
    t_pkt(0, 1'b0);
    t_drain(0);
    t_read(0, "R9");
    chk_irq(0, "R3");

    // R9 non-control endpoint, R5 unstall on it
    t_stall(9);
    t_setup(9);
    t_read(9, "R9");

    // control IN with overwrite cleared after done
    t_setup(1);
    t_done(1);
    t_setup(1);
    t_read(1, "R10");
    t_done(1);
    t_read(1, "R11");

    repeat (4) cyc();
    total++;
    if (exp_w.size() != 0) begin
      bad++;
      $display("FAIL R2 missing reads: actual=%0d expected=0", exp_w.size());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule